// File: doc/BRIEF.md
# Multi-Master Doorbell Interrupt Bank

This block holds a bank of doorbells, one per processor, that processors use to signal each other when they have no coherent memory between them. Each doorbell sits in its own 256-byte register window and holds three pieces of state: a per-master enable mask, a raw record of accepted rings and a pending record of rings that have not been acknowledged. A processor rings a doorbell by writing the value 1 to that doorbell's trigger register. The bus carries a master-ID sideband, and that ID decides which bit the ring records.

The owner of a doorbell chooses which senders it accepts by setting their bits in the enable mask. It services its level interrupt by reading the pending register and writing the same value back. The bank has several independent request ports, one per bus initiator, and all ports are served in the same cycle. Two rules settle conflicts between ports: when several ports write one enable register, the lowest-numbered port wins; when a new ring and a clear hit the same pending bit, the ring wins. Reads return the state as it was before that cycle's writes, one cycle after the request.

Top module: `doorbell_bank`

## Requirements
- R1: After a synchronous active-low reset, every enable, raw and pending register is zero, every interrupt output is low and every read-data port is zero.
- R2: Doorbell d's registers sit at byte address d*0x100 plus a register offset. The offsets are 0x0 trigger, 0x4 enable, 0x8 raw and 0xC pending, and address bits [1:0] are ignored. An access to a doorbell index of NUM_DB or above, or to an offset from 0x10 to 0xFF, changes nothing and reads 0.
- R3: A write of exactly 32'h1 to a trigger register, carrying master ID m, sets bit m of that doorbell's raw and pending registers when bit m of the enable register held before that cycle is 1. A trigger write of any other value has no effect.
- R4: A ring from a master whose enable bit is 0 leaves both raw and pending unchanged.
- R5: The enable register is a 32-bit read/write register. Writing it does not alter raw or pending.
- R6: A write to the pending register clears every bit set in the written data, in both pending and raw, and leaves the other bits alone. Writes to the raw register are ignored.
- R7: A doorbell's interrupt output is high exactly while its pending register is non-zero. It rises in the cycle after the write edge that accepts a ring, and it falls in the cycle after the clear edge that empties pending.
- R8: When one port rings master bit m of a doorbell and another port clears bit m in the same cycle, the bit ends set in both raw and pending.
- R9: When more than one port writes the same enable register in one cycle, the value from the lowest-numbered port is stored.
- R10: Read data appears on the port's read-data output in the cycle after a read request and holds the register value from before any write in the request cycle. A trigger read, a write and an idle cycle all give 0.
- R11: Master ID value m maps to enable, raw and pending bit m. In particular, IDs 17 and 19 map to bits 17 and 19.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| req_valid_i | input | NUM_PORTS | Request valid, one bit per port |
| req_write_i | input | NUM_PORTS | 1 selects a write, 0 a read |
| req_addr_i | input | NUM_PORTS x ADDR_W | Byte address within the bank |
| req_wdata_i | input | NUM_PORTS x 32 | Write data |
| req_mid_i | input | NUM_PORTS x 5 | Master ID of the initiator on each port |
| rsp_rdata_o | output | NUM_PORTS x 32 | Registered read data |
| irq_o | output | NUM_DB | Level interrupt for each doorbell, active high |

## Verification
Directed patterns pin down single effects. Rings with IDs 17 and 19 show that the ID chooses the bit. A ring carrying a non-unit value and a ring from a disabled master must change nothing. A same-cycle ring and clear on two ports separates ring-wins from clear-wins, and a same-cycle enable write from both ports shows which port has priority. Out-of-range doorbells and unused offsets must neither change state nor return data. Random traffic then mixes both ports over every register, in-range and out-of-range addresses, and IDs weighted towards the enabled bits, and a bench model checks each interrupt and read result. This catches ordering faults such as a ring judged against the newly written enable value, or a read that returns post-write state.

// File: rtl/doorbell_pkg.sv
// Shared definitions for the doorbell bank.
// Assumes 32-bit data and 32 master IDs (5-bit ID sideband).
package doorbell_pkg;
    localparam int DATA_W    = 32;
    localparam int MID_W     = 5;
    localparam int WIN_BITS  = 8;          // 256-byte window per doorbell
    localparam logic [DATA_W-1:0] RING_CODE = 32'h0000_0001;

    // Register select decoded from address bits [3:2]; order fixed by the map.
    typedef enum logic [1:0] {
        REG_TRIG = 2'd0,
        REG_EN   = 2'd1,
        REG_RAW  = 2'd2,
        REG_PEND = 2'd3
    } db_reg_e;
endpackage

// File: rtl/doorbell_decode.sv
// Address decoder for one request port.
// Splits the byte address into a doorbell index and a register select and
// flags a hit only for an existing doorbell and an offset below 0x10.
// Assumes ADDR_W > WIN_BITS and NUM_DB <= 2**(ADDR_W-WIN_BITS).
module doorbell_decode
    import doorbell_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NUM_DB = 4,
    parameter int IDX_W  = ADDR_W - WIN_BITS
) (
    input  logic              valid_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [IDX_W-1:0]  idx_o,
    output db_reg_e           reg_o
);
    logic idx_ok;
    logic off_ok;

    // Split the address into its fields.
    always_comb begin
        idx_o  = addr_i[ADDR_W-1:WIN_BITS];
        reg_o  = db_reg_e'(addr_i[3:2]);
        idx_ok = ({1'b0, idx_o} < (IDX_W+1)'(NUM_DB));
        off_ok = (addr_i[WIN_BITS-1:4] == '0);
    end

    // A hit needs a valid request inside an existing window and offset.
    assign hit_o = valid_i && idx_ok && off_ok;
endmodule

// File: rtl/doorbell_slot.sv
// State for one doorbell: enable mask, raw record, pending record, interrupt.
// Takes per-port strobes that are already decoded for this doorbell. A ring
// is judged against the enable value held before the cycle, a ring beats a
// same-cycle clear, and the lowest port wins an enable write conflict.
module doorbell_slot
    import doorbell_pkg::*;
#(
    parameter int NUM_PORTS = 2
) (
    input  logic                                clk_i,
    input  logic                                rst_ni,
    input  logic [NUM_PORTS-1:0]                wr_trig_i,
    input  logic [NUM_PORTS-1:0]                wr_en_i,
    input  logic [NUM_PORTS-1:0]                wr_pend_i,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0]    wdata_i,
    input  logic [NUM_PORTS-1:0][MID_W-1:0]     mid_i,
    output logic [DATA_W-1:0]                   en_o,
    output logic [DATA_W-1:0]                   raw_o,
    output logic [DATA_W-1:0]                   pend_o,
    output logic                                irq_o
);
    logic [DATA_W-1:0] en_q, raw_q, pend_q;
    logic [DATA_W-1:0] ring_vec, accept, clr_vec, en_next;

    // Gather rings and clears from all ports; lowest port sets enable.
    always_comb begin
        ring_vec = '0;
        clr_vec  = '0;
        en_next  = en_q;
        for (int p = NUM_PORTS - 1; p >= 0; p--) begin
            if (wr_trig_i[p] && (wdata_i[p] == RING_CODE))
                ring_vec = ring_vec | (DATA_W'(1) << mid_i[p]);
            if (wr_pend_i[p])
                clr_vec = clr_vec | wdata_i[p];
            if (wr_en_i[p])
                en_next = wdata_i[p];
        end
        accept = ring_vec & en_q;
    end

    // Register update: clear first, then merge accepted rings.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            en_q   <= '0;
            raw_q  <= '0;
            pend_q <= '0;
        end else begin
            en_q   <= en_next;
            raw_q  <= (raw_q  & ~clr_vec) | accept;
            pend_q <= (pend_q & ~clr_vec) | accept;
        end
    end

    assign en_o   = en_q;
    assign raw_o  = raw_q;
    assign pend_o = pend_q;
    assign irq_o  = |pend_q;

    // R4: a raw bit can only appear for a master that was enabled.
    a_r4_disabled_ring_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(en_q)) == '0));

    // R6: pending never holds a bit that raw lacks.
    a_r6_pending_within_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((pend_q & ~raw_q) == '0));

    // R7: the interrupt rises only after an accepted ring.
    a_r7_irq_rise_needs_ring: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> ($past(accept) != '0));

    // R8: every accepted ring is pending afterwards, even against a clear.
    a_r8_ring_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (($past(accept) & ~pend_q) == '0));

    // R9: a write from port 0 always lands in enable.
    a_r9_port0_enable_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i[0] |=> (en_q == $past(wdata_i[0])));
endmodule

// File: rtl/doorbell_rdmux.sv
// Read-data path for one port: selects the addressed register of the
// addressed doorbell and registers it. Idle, write and miss cycles give 0.
// Assumes the index is only used when rd_i is high (decode hit).
module doorbell_rdmux
    import doorbell_pkg::*;
#(
    parameter int NUM_DB = 4,
    parameter int IDX_W  = 4
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           rd_i,
    input  logic [IDX_W-1:0]               idx_i,
    input  db_reg_e                        reg_i,
    input  logic [NUM_DB-1:0][DATA_W-1:0]  en_i,
    input  logic [NUM_DB-1:0][DATA_W-1:0]  raw_i,
    input  logic [NUM_DB-1:0][DATA_W-1:0]  pend_i,
    output logic [DATA_W-1:0]              rdata_o
);
    logic [DATA_W-1:0] sel_val;
    logic              trig_rd;

    // Pick the register value for the addressed doorbell.
    always_comb begin
        sel_val = '0;
        trig_rd = rd_i && (reg_i == REG_TRIG);
        for (int d = 0; d < NUM_DB; d++) begin
            if (rd_i && (idx_i == IDX_W'(d))) begin
                unique case (reg_i)
                    REG_TRIG: sel_val = '0;
                    REG_EN:   sel_val = en_i[d];
                    REG_RAW:  sel_val = raw_i[d];
                    REG_PEND: sel_val = pend_i[d];
                endcase
            end
        end
    end

    // Register the read result; zero when no read is served.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) rdata_o <= '0;
        else         rdata_o <= sel_val;
    end

    // R10: a trigger read returns zero.
    a_r10_trigger_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_rd |=> (rdata_o == '0));
endmodule

// File: rtl/doorbell_bank.sv
// Bank of NUM_DB doorbells served by NUM_PORTS request ports, each with its
// own master-ID sideband. One decoder and one read path per port, one state
// slot per doorbell. Assumes all ports share clk_i and that each port's
// master ID is valid whenever that port issues a trigger write.
module doorbell_bank
    import doorbell_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int NUM_DB    = 4,
    parameter int ADDR_W    = 12
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic [NUM_PORTS-1:0]              req_valid_i,
    input  logic [NUM_PORTS-1:0]              req_write_i,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  req_addr_i,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0]  req_wdata_i,
    input  logic [NUM_PORTS-1:0][MID_W-1:0]   req_mid_i,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]  rsp_rdata_o,
    output logic [NUM_DB-1:0]                 irq_o
);
    localparam int IDX_W = ADDR_W - WIN_BITS;

    logic [NUM_PORTS-1:0]              hit;
    logic [NUM_PORTS-1:0][IDX_W-1:0]   idx;
    db_reg_e                           rsel [NUM_PORTS];

    logic [NUM_DB-1:0][NUM_PORTS-1:0]  wr_trig, wr_en, wr_pend;
    logic [NUM_DB-1:0][DATA_W-1:0]     en_all, raw_all, pend_all;

    // One decoder and one read path per port.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        doorbell_decode #(
            .ADDR_W (ADDR_W),
            .NUM_DB (NUM_DB),
            .IDX_W  (IDX_W)
        ) u_dec (
            .valid_i (req_valid_i[p]),
            .addr_i  (req_addr_i[p]),
            .hit_o   (hit[p]),
            .idx_o   (idx[p]),
            .reg_o   (rsel[p])
        );

        doorbell_rdmux #(
            .NUM_DB (NUM_DB),
            .IDX_W  (IDX_W)
        ) u_rd (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .rd_i    (hit[p] && !req_write_i[p]),
            .idx_i   (idx[p]),
            .reg_i   (rsel[p]),
            .en_i    (en_all),
            .raw_i   (raw_all),
            .pend_i  (pend_all),
            .rdata_o (rsp_rdata_o[p])
        );
    end

    // One state slot per doorbell, fed by the per-port write strobes.
    for (genvar d = 0; d < NUM_DB; d++) begin : g_db
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_strb
            logic wr_here;
            assign wr_here       = hit[p] && req_write_i[p] && (idx[p] == IDX_W'(d));
            assign wr_trig[d][p] = wr_here && (rsel[p] == REG_TRIG);
            assign wr_en[d][p]   = wr_here && (rsel[p] == REG_EN);
            assign wr_pend[d][p] = wr_here && (rsel[p] == REG_PEND);
        end

        doorbell_slot #(
            .NUM_PORTS (NUM_PORTS)
        ) u_slot (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .wr_trig_i (wr_trig[d]),
            .wr_en_i   (wr_en[d]),
            .wr_pend_i (wr_pend[d]),
            .wdata_i   (req_wdata_i),
            .mid_i     (req_mid_i),
            .en_o      (en_all[d]),
            .raw_o     (raw_all[d]),
            .pend_o    (pend_all[d]),
            .irq_o     (irq_o[d])
        );
    end

    // R2: a request that misses the map leaves every interrupt unchanged.
    a_r2_miss_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i != '0 && hit == '0) |=> $stable(irq_o));

    // R1: interrupts are low in the cycle after reset is applied.
    a_r1_reset_clears_irq: assert property (@(posedge clk_i)
        !rst_ni |=> (irq_o == '0));
endmodule

// File: tb/doorbell_bank_tb.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// checked against a behavioural model of the requirements.
module doorbell_bank_tb;
    localparam int P  = 2;
    localparam int ND = 4;
    localparam int AW = 12;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [P-1:0]        p_val, p_we;
    logic [P-1:0][AW-1:0] p_addr;
    logic [P-1:0][31:0]  p_wd;
    logic [P-1:0][4:0]   p_mid;
    logic [P-1:0][31:0]  p_rd;
    logic [ND-1:0]       irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] m_en [ND];
    logic [31:0] m_raw[ND];
    logic [31:0] m_pnd[ND];

    always #5 clk = ~clk;

    doorbell_bank #(.NUM_PORTS(P), .NUM_DB(ND), .ADDR_W(AW)) u_dut (
        .clk_i(clk), .rst_ni(rst_n),
        .req_valid_i(p_val), .req_write_i(p_we), .req_addr_i(p_addr),
        .req_wdata_i(p_wd), .req_mid_i(p_mid),
        .rsp_rdata_o(p_rd), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit hit(input int p, output int d, output int r);
        d = int'(p_addr[p][AW-1:8]);
        r = int'(p_addr[p][3:2]);
        return p_val[p] && d < ND && p_addr[p][7:4] == 4'h0;
    endfunction

    task automatic idle();
        p_val = '0; p_we = '0; p_addr = '0; p_wd = '0; p_mid = '0;
    endtask

    task automatic req(input int p, input bit we, input int db, input int off,
                       input logic [31:0] wd, input int mid);
        p_val[p]  = 1'b1;
        p_we[p]   = we;
        p_addr[p] = AW'(db * 256 + off);
        p_wd[p]   = wd;
        p_mid[p]  = 5'(mid);
    endtask

    // Apply the current inputs for one cycle and check against the model.
    task automatic step(input string tag);
        logic [31:0] exp_rd[P];
        logic [31:0] ring, clr, en_n, acc;
        logic [ND-1:0] exp_irq;
        int d, r;
        for (int p = 0; p < P; p++) begin
            exp_rd[p] = '0;
            if (hit(p, d, r) && !p_we[p])
                exp_rd[p] = (r == 1) ? m_en[d] : (r == 2) ? m_raw[d] : (r == 3) ? m_pnd[d] : 32'h0;
        end
        for (int k = 0; k < ND; k++) begin
            ring = '0; clr = '0; en_n = m_en[k];
            for (int p = P - 1; p >= 0; p--) begin
                if (hit(p, d, r) && p_we[p] && d == k) begin
                    if (r == 1) en_n = p_wd[p];
                    if (r == 0 && p_wd[p] == 32'h1) ring = ring | (32'h1 << p_mid[p]);
                    if (r == 3) clr = clr | p_wd[p];
                end
            end
            acc = ring & m_en[k];
            m_raw[k] = (m_raw[k] & ~clr) | acc;
            m_pnd[k] = (m_pnd[k] & ~clr) | acc;
            m_en[k]  = en_n;
            exp_irq[k] = |m_pnd[k];
        end
        @(posedge clk);
        #2;
        chk({tag, " irq"}, 32'(irq), 32'(exp_irq));
        for (int p = 0; p < P; p++) chk({tag, " rdata"}, p_rd[p], exp_rd[p]);
        @(negedge clk);
        idle();
    endtask

    // Read one register through port 0 and let step() compare it.
    task automatic rd(input string tag, input int db, input int off);
        req(0, 1'b0, db, off, 32'h0, 0);
        step(tag);
        step(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        idle();
        for (int k = 0; k < ND; k++) begin m_en[k] = '0; m_raw[k] = '0; m_pnd[k] = '0; end
        repeat (3) @(posedge clk);
        #2;
        // R1: outputs during reset
        chk("R1 irq in reset", 32'(irq), 32'h0);
        chk("R1 rdata in reset", p_rd[0], 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: registers zero after reset
        for (int k = 0; k < ND; k++) begin
            rd("R1 en", k, 4); rd("R1 raw", k, 8); rd("R1 pend", k, 12);
        end
        // R5: enable hosts 17 and 19 on doorbell 0 and read back
        req(0, 1'b1, 0, 4, 32'h000A_0000, 0); step("R5 en write");
        rd("R5 en readback", 0, 4);
        // R11 / R3: ring from ID 17
        req(1, 1'b1, 0, 0, 32'h1, 17); step("R11 ring id17");
        rd("R11 raw bit17", 0, 8); rd("R3 pend bit17", 0, 12);
        // R3: non-unit value from ID 19 is ignored
        req(0, 1'b1, 0, 0, 32'h3, 19); step("R3 bad code");
        rd("R3 pend unchanged", 0, 12);
        // R4: disabled ID 5 is ignored
        req(0, 1'b1, 0, 0, 32'h1, 5); step("R4 disabled ring");
        rd("R4 raw unchanged", 0, 8);
        // R8: ring 19 on port 0 while port 1 clears 17 and 19
        req(0, 1'b1, 0, 0, 32'h1, 19);
        req(1, 1'b1, 0, 12, 32'h000A_0000, 0); step("R8 ring vs clear");
        rd("R8 pend", 0, 12); rd("R8 raw", 0, 8);
        // R6: raw write ignored, then clear bit 19 drops irq
        req(0, 1'b1, 0, 8, 32'hFFFF_FFFF, 0); step("R6 raw write");
        rd("R6 raw kept", 0, 8);
        req(1, 1'b1, 0, 12, 32'h0008_0000, 0); step("R6 clear");
        rd("R6 raw cleared", 0, 8);
        // R9: both ports write enable of doorbell 1
        req(0, 1'b1, 1, 4, 32'h1234_5678, 0);
        req(1, 1'b1, 1, 4, 32'h8765_4321, 0); step("R9 en conflict");
        rd("R9 port0 value", 1, 4);
        // R2: out-of-range doorbell and unused offset
        req(0, 1'b1, ND, 4, 32'hFFFF_FFFF, 0); step("R2 bad index");
        req(1, 1'b1, 1, 16, 32'h0, 0); step("R2 bad offset");
        rd("R2 en intact", 1, 4); rd("R2 miss reads 0", 1, 16); rd("R2 high index reads 0", ND, 4);
        // R10: trigger reads return 0; read sees pre-write state
        rd("R10 trig read", 1, 0);
        req(0, 1'b0, 1, 4, 32'h0, 0);
        req(1, 1'b1, 1, 4, 32'h0000_00FF, 0); step("R10 read before write");
        // R7: random mixed traffic, irq and reads checked each cycle
        for (int i = 0; i < 4000; i++) begin
            for (int p = 0; p < P; p++) begin
                int db, off, sel;
                logic [31:0] wd;
                if ($urandom % 4 != 0) begin
                    db  = int'($urandom % (ND + 1));
                    sel = int'($urandom % 4);
                    off = ($urandom % 10 == 0) ? 16 * (1 + int'($urandom % 15)) : sel * 4 + int'($urandom % 4);
                    wd  = (sel == 0) ? (($urandom % 5 == 0) ? $urandom : 32'h1) :
                          (sel == 1) ? ($urandom | 32'h000A_0000) : $urandom;
                    req(p, ($urandom % 2) == 1, db, off, wd,
                        ($urandom % 2) ? int'($urandom % 32) : (($urandom % 2) ? 17 : 19));
                end
            end
            step("R7 random");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule